// File: doc/BRIEF.md
# Associative Tag Lookup with Recency-Based Victim Selection

This block is a small fully associative tag store. It holds sixteen slots. Each slot has a 32-bit tag, a 4-bit state nibble that belongs to software, and a valid flag. A lookup strobe presents a key, which is compared against every slot at the same time. One clock later the block returns a single 9-bit result word.

On a hit, the result names the matching slot and carries its state nibble. On a miss, it names the slot that software should refill: an empty slot if one exists, otherwise the slot touched longest ago. A write port loads a tag and a state nibble into a chosen slot. A clear input empties the whole store.

The hardware keeps the recency order itself. A hit and a write each move the slot they touch to the newest position. A miss leaves the order unchanged. The state nibble is stored and returned as is and is never decoded.

Top module: `lru_cam`

## Requirements
- R1: After reset, and after any cycle with `clear_i` high, every slot is invalid and the recency order runs from slot 0 (oldest) to slot 15 (newest). A lookup that follows therefore misses with index 0.
- R2: `res_valid_o` is high in exactly the cycle after a cycle with `lkp_valid_i` high and `clear_i` low, and low otherwise. `res_o` carries the result of that lookup.
- R3: On a hit, `res_o[8]` is 1, `res_o[3:0]` is the index of the matching slot and `res_o[7:4]` is that slot's state nibble, returned unchanged whatever its value.
- R4: On a miss, `res_o[8]` is 0 and `res_o[7:4]` is 0.
- R5: On a miss while any slot is invalid, `res_o[3:0]` is the lowest-numbered invalid slot. An invalid slot never hits.
- R6: On a miss while all slots are valid, `res_o[3:0]` is the least recently used slot.
- R7: A lookup hit makes the matching slot most recently used. A lookup miss leaves the recency order unchanged.
- R8: A write with `clear_i` low stores `wr_tag_i` and `wr_state_i` into slot `wr_idx_i`, marks the slot valid and makes it most recently used. It overwrites any earlier contents.
- R9: When several valid slots hold the key, the lowest-numbered one is reported.
- R10: A lookup and a write in the same cycle: the lookup sees the contents from before the write. The hit slot is touched first and the written slot last. `clear_i` overrides a write in the same cycle and suppresses the result of a lookup in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Invalidate all slots and restore the initial recency order |
| lkp_valid_i | input | 1 | Lookup strobe |
| lkp_key_i | input | 32 | Key to search for |
| wr_en_i | input | 1 | Slot write strobe |
| wr_idx_i | input | 4 | Slot to write |
| wr_tag_i | input | 32 | Tag to store |
| wr_state_i | input | 4 | Software state nibble to store |
| res_valid_o | output | 1 | Result present this cycle |
| res_o | output | 9 | Result word {hit, state[3:0], index[3:0]} |

## Verification
The bench fills the store, then builds a known recency order with hits. It checks four things that a wrong design would get wrong:
- After a hit on the oldest slot, the victim moves on to the next slot. A design that drops the touch would keep returning the same victim.
- Repeated misses return the same victim. A design that touches on a miss would make the victim wander.
- With a duplicated tag, the lower slot must be reported. Priority in the wrong direction would report the higher one.
- A lookup issued together with a write of the same key must miss. It must also not leave stale valid bits behind a clear.

A long random phase with a small key pool mixes hits, misses, overwrites and clears. This exposes errors in the victim choice between invalid and least-recent slots.

// File: rtl/cam_pkg.sv
package cam_pkg;
    localparam int CAM_ENTRIES = 16;
    localparam int CAM_TAG_W   = 32;
    localparam int CAM_STATE_W = 4;
endpackage

// File: rtl/cam_store.sv
module cam_store #(
    parameter int ENTRIES = cam_pkg::CAM_ENTRIES,
    parameter int TAG_W   = cam_pkg::CAM_TAG_W,
    parameter int STATE_W = cam_pkg::CAM_STATE_W,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clear_i,
    input  logic                             wr_en_i,
    input  logic [IDX_W-1:0]                 wr_idx_i,
    input  logic [TAG_W-1:0]                 wr_tag_i,
    input  logic [STATE_W-1:0]               wr_state_i,
    output logic [ENTRIES-1:0][TAG_W-1:0]    tags_o,
    output logic [ENTRIES-1:0][STATE_W-1:0]  states_o,
    output logic [ENTRIES-1:0]               valid_o
);
    typedef struct packed {
        logic [ENTRIES-1:0][TAG_W-1:0]   tag;
        logic [ENTRIES-1:0][STATE_W-1:0] st;
        logic [ENTRIES-1:0]              vld;
    } store_t;

    store_t store_d, store_q;

    always_comb begin
        store_d = store_q;
        if (clear_i) begin
            store_d.vld = '0;
        end else if (wr_en_i && (int'(wr_idx_i) < ENTRIES)) begin
            store_d.tag[wr_idx_i] = wr_tag_i;
            store_d.st[wr_idx_i]  = wr_state_i;
            store_d.vld[wr_idx_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) store_q <= '0;
        else        store_q <= store_d;
    end

    assign tags_o   = store_q.tag;
    assign states_o = store_q.st;
    assign valid_o  = store_q.vld;
endmodule

// File: rtl/cam_match.sv
module cam_match #(
    parameter int ENTRIES = cam_pkg::CAM_ENTRIES,
    parameter int TAG_W   = cam_pkg::CAM_TAG_W,
    parameter int STATE_W = cam_pkg::CAM_STATE_W,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [TAG_W-1:0]                 key_i,
    input  logic [ENTRIES-1:0][TAG_W-1:0]    tags_i,
    input  logic [ENTRIES-1:0][STATE_W-1:0]  states_i,
    input  logic [ENTRIES-1:0]               valid_i,
    output logic                             hit_o,
    output logic [IDX_W-1:0]                 hit_idx_o,
    output logic [STATE_W-1:0]               hit_state_o,
    output logic [IDX_W-1:0]                 free_idx_o,
    output logic                             any_free_o
);
    logic [ENTRIES-1:0] eq;

    // One comparator per slot; invalid slots are masked out.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = valid_i[g] && (tags_i[g] == key_i);
    end

    // Scan from the top so that the lowest index is written last and wins.
    always_comb begin
        hit_o       = 1'b0;
        hit_idx_o   = '0;
        hit_state_o = '0;
        any_free_o  = 1'b0;
        free_idx_o  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit_o       = 1'b1;
                hit_idx_o   = IDX_W'(i);
                hit_state_o = states_i[i];
            end
            if (!valid_i[i]) begin
                any_free_o = 1'b1;
                free_idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/cam_lru_order.sv
module cam_lru_order #(
    parameter int ENTRIES = cam_pkg::CAM_ENTRIES,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             touch_a_i,
    input  logic [IDX_W-1:0] touch_a_idx_i,
    input  logic             touch_b_i,
    input  logic [IDX_W-1:0] touch_b_idx_i,
    output logic [IDX_W-1:0] oldest_o
);
    // Position 0 holds the oldest slot, position ENTRIES-1 the newest.
    typedef logic [ENTRIES-1:0][IDX_W-1:0] order_t;

    order_t order_d, order_q;

    function automatic order_t initial_order();
        order_t o;
        for (int i = 0; i < ENTRIES; i++) o[i] = IDX_W'(i);
        return o;
    endfunction

    function automatic order_t move_to_newest(order_t o, logic [IDX_W-1:0] x);
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < ENTRIES - 1; i++) begin
            if (o[i] == x) seen = 1'b1;
            if (seen) o[i] = o[i+1];
        end
        o[ENTRIES-1] = x;
        return o;
    endfunction

    always_comb begin
        order_d = order_q;
        if (clear_i) begin
            order_d = initial_order();
        end else begin
            if (touch_a_i) order_d = move_to_newest(order_d, touch_a_idx_i);
            if (touch_b_i) order_d = move_to_newest(order_d, touch_b_idx_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) order_q <= initial_order();
        else        order_q <= order_d;
    end

    assign oldest_o = order_q[0];
endmodule

// File: rtl/lru_cam.sv
module lru_cam #(
    parameter int ENTRIES = cam_pkg::CAM_ENTRIES,
    parameter int TAG_W   = cam_pkg::CAM_TAG_W,
    parameter int STATE_W = cam_pkg::CAM_STATE_W,
    parameter int IDX_W   = $clog2(ENTRIES),
    parameter int RES_W   = 1 + STATE_W + IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               lkp_valid_i,
    input  logic [TAG_W-1:0]   lkp_key_i,
    input  logic               wr_en_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic [TAG_W-1:0]   wr_tag_i,
    input  logic [STATE_W-1:0] wr_state_i,
    output logic               res_valid_o,
    output logic [RES_W-1:0]   res_o
);
    typedef struct packed {
        logic               vld;
        logic               hit;
        logic [STATE_W-1:0] st;
        logic [IDX_W-1:0]   idx;
    } res_t;

    res_t res_d, res_q;

    logic [ENTRIES-1:0][TAG_W-1:0]   tags;
    logic [ENTRIES-1:0][STATE_W-1:0] states;
    logic [ENTRIES-1:0]              valid;
    logic                            hit;
    logic [IDX_W-1:0]                hit_idx;
    logic [STATE_W-1:0]              hit_state;
    logic [IDX_W-1:0]                free_idx;
    logic                            any_free;
    logic [IDX_W-1:0]                oldest;
    logic                            touch_hit;
    logic                            touch_wr;

    cam_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .STATE_W(STATE_W), .IDX_W(IDX_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_i),
        .wr_en_i    (wr_en_i),
        .wr_idx_i   (wr_idx_i),
        .wr_tag_i   (wr_tag_i),
        .wr_state_i (wr_state_i),
        .tags_o     (tags),
        .states_o   (states),
        .valid_o    (valid)
    );

    cam_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .STATE_W(STATE_W), .IDX_W(IDX_W)) u_match (
        .key_i       (lkp_key_i),
        .tags_i      (tags),
        .states_i    (states),
        .valid_i     (valid),
        .hit_o       (hit),
        .hit_idx_o   (hit_idx),
        .hit_state_o (hit_state),
        .free_idx_o  (free_idx),
        .any_free_o  (any_free)
    );

    assign touch_hit = lkp_valid_i && hit && !clear_i;
    assign touch_wr  = wr_en_i && !clear_i;

    cam_lru_order #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_order (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear_i       (clear_i),
        .touch_a_i     (touch_hit),
        .touch_a_idx_i (hit_idx),
        .touch_b_i     (touch_wr),
        .touch_b_idx_i (wr_idx_i),
        .oldest_o      (oldest)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = lkp_valid_i && !clear_i;
        if (res_d.vld) begin
            if (hit) begin
                res_d.hit = 1'b1;
                res_d.st  = hit_state;
                res_d.idx = hit_idx;
            end else begin
                res_d.hit = 1'b0;
                res_d.st  = '0;
                res_d.idx = any_free ? free_idx : oldest;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid_o = res_q.vld;
    assign res_o       = {res_q.hit, res_q.st, res_q.idx};
endmodule

// File: rtl/lru_cam_checker.sv
module lru_cam_checker #(
    parameter int TAG_W   = 32,
    parameter int STATE_W = 4,
    parameter int IDX_W   = 4,
    parameter int RES_W   = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clear_i,
    input logic               lkp_valid_i,
    input logic [TAG_W-1:0]   lkp_key_i,
    input logic               wr_en_i,
    input logic [TAG_W-1:0]   wr_tag_i,
    input logic               res_valid_o,
    input logic [RES_W-1:0]   res_o
);
    assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_valid_i && !clear_i) |=> res_valid_o);

    assert_no_spurious_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(lkp_valid_i && !clear_i) |=> !res_valid_o);

    assert_miss_state_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !res_o[RES_W-1]) |-> (res_o[RES_W-2:IDX_W] == '0));

    assert_clear_drops_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !res_valid_o);

    assert_written_tag_hits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_valid_i && !clear_i && !wr_en_i && $past(wr_en_i && !clear_i)
         && (lkp_key_i == $past(wr_tag_i))) |=> (res_valid_o && res_o[RES_W-1]));
endmodule

bind lru_cam lru_cam_checker #(.TAG_W(TAG_W), .STATE_W(STATE_W), .IDX_W(IDX_W), .RES_W(RES_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear_i),
    .lkp_valid_i (lkp_valid_i),
    .lkp_key_i   (lkp_key_i),
    .wr_en_i     (wr_en_i),
    .wr_tag_i    (wr_tag_i),
    .res_valid_o (res_valid_o),
    .res_o       (res_o)
);

// File: tb/tb_lru_cam.sv
module tb_lru_cam;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_i = 1'b0;
    logic        lkp_valid_i = 1'b0;
    logic [31:0] lkp_key_i = '0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  wr_idx_i = '0;
    logic [31:0] wr_tag_i = '0;
    logic [3:0]  wr_state_i = '0;
    logic        res_valid_o;
    logic [8:0]  res_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model
    logic [31:0] m_tag [16];
    logic [3:0]  m_st  [16];
    bit          m_vld [16];
    int          m_ord [16];

    always #2 clk = ~clk;

    lru_cam dut (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
        .lkp_valid_i(lkp_valid_i), .lkp_key_i(lkp_key_i),
        .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_tag_i(wr_tag_i), .wr_state_i(wr_state_i),
        .res_valid_o(res_valid_o), .res_o(res_o)
    );

    function automatic void model_reset();
        for (int i = 0; i < 16; i++) begin
            m_vld[i] = 0;
            m_ord[i] = i;
        end
    endfunction

    function automatic void model_touch(int x);
        bit seen = 0;
        for (int i = 0; i < 15; i++) begin
            if (m_ord[i] == x) seen = 1;
            if (seen) m_ord[i] = m_ord[i+1];
        end
        m_ord[15] = x;
    endfunction

    function automatic int model_hit(logic [31:0] key);
        for (int i = 0; i < 16; i++)
            if (m_vld[i] && m_tag[i] == key) return i;
        return -1;
    endfunction

    function automatic logic [8:0] model_result(logic [31:0] key);
        int h = model_hit(key);
        if (h >= 0) return {1'b1, m_st[h], 4'(h)};
        for (int i = 0; i < 16; i++)
            if (!m_vld[i]) return {1'b0, 4'b0, 4'(i)};
        return {1'b0, 4'b0, 4'(m_ord[0])};
    endfunction

    function automatic bit model_all_valid();
        for (int i = 0; i < 16; i++) if (!m_vld[i]) return 0;
        return 1;
    endfunction

    task automatic check(bit ok, string req, logic [8:0] act, logic [8:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, sample just after the edge, then update model.
    task automatic step(bit lk, logic [31:0] key, bit wr, int widx, logic [31:0] wtag,
                        logic [3:0] wst, bit clr, string req);
        logic [8:0] exp;
        bit exp_v;
        int h;
        string r;
        exp   = model_result(key);
        exp_v = lk && !clr;
        h     = model_hit(key);
        r     = req;
        if (r == "") r = (h >= 0) ? "R3" : (model_all_valid() ? "R6" : "R5");
        lkp_valid_i = lk; lkp_key_i = key;
        wr_en_i = wr; wr_idx_i = 4'(widx); wr_tag_i = wtag; wr_state_i = wst;
        clear_i = clr;
        @(posedge clk);
        #1;
        if (exp_v) begin
            check(res_valid_o === 1'b1 && res_o === exp, r, {res_valid_o, res_o[7:0]}, exp);
        end else begin
            check(res_valid_o === 1'b0, "R2", {8'b0, res_valid_o}, 9'd0);
        end
        if (clr) begin
            model_reset();
        end else begin
            if (lk && h >= 0) model_touch(h);
            if (wr) begin
                m_tag[widx] = wtag; m_st[widx] = wst; m_vld[widx] = 1; model_touch(widx);
            end
        end
        @(negedge clk);
        lkp_valid_i = 0; wr_en_i = 0; clear_i = 0;
    endtask

    task automatic lookup(logic [31:0] key, string req);
        step(1, key, 0, 0, 0, 0, 0, req);
    endtask

    task automatic write(int idx, logic [31:0] tag, logic [3:0] st);
        step(0, 0, 1, idx, tag, st, 0, "R2");
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_cafe));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_valid_o === 1'b0, "R1", {8'b0, res_valid_o}, 9'd0);

        // R1: empty store misses with victim 0
        lookup(32'hdead_beef, "R1");
        // R5: fill a few, victim is lowest invalid
        write(0, 32'h100, 4'h3);
        write(2, 32'h102, 4'hf);
        lookup(32'h999, "R5");              // expect idx 1
        lookup(32'h102, "R3");              // state 0xf returned
        // R8: fill all slots
        for (int i = 0; i < 16; i++) write(i, 32'h200 + i, 4'(i));
        for (int i = 0; i < 16; i++) lookup(32'h200 + i, "R8");
        // Order now 0 oldest .. 15 newest; hit 0 moves victim to 1
        lookup(32'h200, "R7");
        lookup(32'h777, "R7");              // miss, victim 1
        lookup(32'h778, "R7");              // miss again, still 1
        lookup(32'h779, "R6");
        // R9: duplicate tag in slots 3 and 9
        write(9, 32'h203, 4'ha);
        lookup(32'h203, "R9");              // expect slot 3, state 3
        // R10: lookup and write of same new key in one cycle -> miss, then hit
        step(1, 32'hface, 1, 5, 32'hface, 4'h6, 0, "R10");
        lookup(32'hface, "R10");
        // R10: clear with lookup and write -> no result, write dropped
        step(1, 32'h201, 1, 7, 32'h4444, 4'h1, 1, "R10");
        lookup(32'h4444, "R10");            // miss, idx 0
        lookup(32'h201, "R1");              // miss, idx 0

        // Random phase with a small key pool
        for (int n = 0; n < 4000; n++) begin
            bit lk  = ($urandom % 4) != 0;
            bit wr  = ($urandom % 3) == 0;
            bit clr = ($urandom % 200) == 0;
            logic [31:0] key  = 32'h3000 + ($urandom % 24);
            logic [31:0] wtag = 32'h3000 + ($urandom % 24);
            step(lk, key, wr, int'($urandom % 16), wtag, 4'($urandom), clr, "");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule